// File: doc/BRIEF.md
# Dual-Law Serial Clock Generator

This block derives the serial clock of a synchronous serial master from its module clock. A control word holds two divider fields and a law-select bit. The bit chooses between an even linear divide, `2*(N+1)`, and a power-of-two divide, `2^(N+1)`. The generator drives the serial clock level and two single-cycle strobes. One strobe marks the edge that leaves the idle level and the other marks the edge that returns to it. The shift engine uses these strobes to launch and sample data.

The generator runs only while `run_i` is high. While `run_i` is low, the control word and the idle polarity are captured on every clock edge. The half-period counter stays cleared and the clock rests at the idle level. As a result, the first half-period of a transfer always has full length. A control word that changes during a transfer takes effect only at the next transfer. Choosing divider values for a target rate is left to software.

Top module: `sclk_div_gen`

## Requirements
- R1: While `rst_ni` is low, `sclk_o`, `lead_o` and `trail_o` are all 0.
- R2: While `run_i` is low, `sclk_o` settles to `cpol_i` and both strobes stay 0.
- R3: When `ctl_i[12]` is 1 (linear law), each half-period of `sclk_o` lasts `ctl_i[7:0]+1` module clocks, and `ctl_i[11:8]` has no effect.
- R4: When `ctl_i[12]` is 0 (power-of-two law), each half-period lasts `2^ctl_i[11:8]` module clocks, and `ctl_i[7:0]` has no effect. N=0 in either law gives the fastest ratio, divide by 2.
- R5: The first toggle of `sclk_o` follows the H-th rising clock edge that samples `run_i` high, where H is the half-period length. Every later toggle comes H edges after the previous one.
- R6: `lead_o` is 1 for exactly the cycle in which `sclk_o` first shows a level different from the idle level.
- R7: `trail_o` is 1 for exactly the cycle in which `sclk_o` first shows its return to the idle level.
- R8: Changes to `ctl_i` or `cpol_i` while `run_i` is high have no effect until `run_i` has been low for at least one clock edge.
- R9: After the first clock edge that samples `run_i` low, `sclk_o` is at the captured idle level and both strobes are 0.
- R10: `lead_o` and `trail_o` are never 1 together, and one of them is 1 whenever `sclk_o` changes during a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Transfer active; the generator runs while high |
| cpol_i | input | 1 | Idle level of the serial clock |
| ctl_i | input | 13 | [7:0] linear N, [11:8] power-of-two N, [12] law select (1 = linear) |
| sclk_o | output | 1 | Serial clock |
| lead_o | output | 1 | One-cycle strobe on the edge leaving idle |
| trail_o | output | 1 | One-cycle strobe on the edge returning to idle |

## Verification
The settings are captured one edge after they are driven. The idle level reaches `sclk_o` one edge after that. For this reason the bench holds each new setting for three idle cycles before it checks the idle level. After `run_i` rises, the bench counts k, the rising edges that sample it high. The expected toggle count is floor(k/H), and a strobe is due exactly when k is a multiple of H. Outputs are sampled at each falling edge, so every one of these values is compared in the cycle it becomes visible. When `run_i` falls, the idle state is due after one edge and is checked at the next falling edge.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;
  typedef enum logic {
    LAW_POW2 = 1'b0,
    LAW_LIN  = 1'b1
  } law_e;
endpackage

// File: rtl/sclk_cfg_hold.sv
module sclk_cfg_hold
  import sclk_div_pkg::*;
#(
  parameter int LIN_W  = 8,
  parameter int EXP_W  = 4,
  parameter int HALF_W = 16,
  localparam int CTL_W = LIN_W + EXP_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              cpol_i,
  input  logic [CTL_W-1:0]  ctl_i,
  output logic [HALF_W-1:0] half_m1_o,
  output logic              cpol_o
);
  logic [LIN_W-1:0] lin_q;
  logic [EXP_W-1:0] exp_q;
  law_e             law_q;
  logic             cpol_q;

  // settings track the inputs only while idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lin_q  <= '0;
      exp_q  <= '0;
      law_q  <= LAW_POW2;
      cpol_q <= 1'b0;
    end else if (!run_i) begin
      lin_q  <= ctl_i[LIN_W-1:0];
      exp_q  <= ctl_i[LIN_W +: EXP_W];
      law_q  <= law_e'(ctl_i[CTL_W-1]);
      cpol_q <= cpol_i;
    end
  end

  always_comb begin
    if (law_q == LAW_LIN) half_m1_o = HALF_W'(lin_q);
    else                  half_m1_o = (HALF_W'(1) << exp_q) - HALF_W'(1);
  end

  assign cpol_o = cpol_q;
endmodule

// File: rtl/sclk_half_ctr.sv
module sclk_half_ctr #(
  parameter int HALF_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [HALF_W-1:0] half_m1_i,
  output logic              tick_o
);
  logic [HALF_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == half_m1_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + HALF_W'(1);
  end
endmodule

// File: rtl/sclk_edge_gen.sv
module sclk_edge_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic cpol_i,
  input  logic tick_i,
  output logic sclk_o,
  output logic lead_o,
  output logic trail_o
);
  logic sclk_q, lead_q, trail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q  <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else if (!run_i) begin
      sclk_q  <= cpol_i;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else if (tick_i) begin
      sclk_q  <= ~sclk_q;
      lead_q  <= (sclk_q == cpol_i);
      trail_q <= (sclk_q != cpol_i);
    end else begin
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end
  end

  assign sclk_o  = sclk_q;
  assign lead_o  = lead_q;
  assign trail_o = trail_q;
endmodule

// File: rtl/sclk_div_gen.sv
module sclk_div_gen #(
  parameter int LIN_W = 8,
  parameter int EXP_W = 4,
  localparam int CTL_W  = LIN_W + EXP_W + 1,
  localparam int HALF_W = ((1 << EXP_W) > (LIN_W + 1)) ? (1 << EXP_W) : (LIN_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             cpol_i,
  input  logic [CTL_W-1:0] ctl_i,
  output logic             sclk_o,
  output logic             lead_o,
  output logic             trail_o
);
  logic [HALF_W-1:0] half_m1;
  logic              cpol_h;
  logic              tick;

  sclk_cfg_hold #(.LIN_W(LIN_W), .EXP_W(EXP_W), .HALF_W(HALF_W)) u_hold (
    .clk_i, .rst_ni, .run_i, .cpol_i, .ctl_i,
    .half_m1_o(half_m1), .cpol_o(cpol_h)
  );

  sclk_half_ctr #(.HALF_W(HALF_W)) u_ctr (
    .clk_i, .rst_ni, .run_i, .half_m1_i(half_m1), .tick_o(tick)
  );

  sclk_edge_gen u_edge (
    .clk_i, .rst_ni, .run_i, .cpol_i(cpol_h), .tick_i(tick),
    .sclk_o, .lead_o, .trail_o
  );
endmodule

// File: rtl/sclk_div_chk.sv
module sclk_div_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic run_i,
  input logic sclk_o,
  input logic lead_o,
  input logic trail_o
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  a_r10_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lead_o && trail_o));

  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !$past(run_i)) |-> (!lead_o && !trail_o));

  a_r6_lead_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && lead_o) |-> (sclk_o != $past(sclk_o)));

  a_r7_trail_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && trail_o) |-> (sclk_o != $past(sclk_o)));

  a_r10_strobe_cover: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(run_i) && (sclk_o != $past(sclk_o))) |-> (lead_o || trail_o));
endmodule

bind sclk_div_gen sclk_div_chk u_chk (
  .clk_i, .rst_ni, .run_i, .sclk_o, .lead_o, .trail_o
);

// File: tb/tb_sclk_div_gen.sv
module tb_sclk_div_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        run_i = 1'b0;
  logic        cpol_i = 1'b0;
  logic [12:0] ctl_i = '0;
  logic        sclk_o, lead_o, trail_o;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  sclk_div_gen dut (.*);

  task automatic chk(string req, logic [2:0] act, logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {sclk,lead,trail} actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic int half_len(logic [12:0] c);
    return c[12] ? int'(c[7:0]) + 1 : (1 << c[11:8]);
  endfunction

  function automatic logic [2:0] model(logic cp, int k, int h);
    int  t = k / h;
    logic s = (k % h) == 0;
    return {cp ^ t[0], s && t[0], s && !t[0]};
  endfunction

  // R3/R4/R5/R6/R7 per edge; R8 when chg is set; R2 before, R9 after
  task automatic xfer(string req, logic [12:0] c, logic cp, bit chg);
    int h = half_len(c);
    int n = 4 * h + 2;
    @(negedge clk_i);
    ctl_i = c; cpol_i = cp;
    repeat (3) @(negedge clk_i);
    chk("R2 idle", {sclk_o, lead_o, trail_o}, {cp, 2'b00});
    run_i = 1'b1;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk_i);
      if (chg && k == 2) begin
        ctl_i = ~c; cpol_i = ~cp;
      end
      chk(chg ? "R8 frozen" : req, {sclk_o, lead_o, trail_o}, model(cp, k, h));
    end
    run_i = 1'b0;
    @(negedge clk_i);
    chk("R9 stop", {sclk_o, lead_o, trail_o}, {cp, 2'b00});
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed = $urandom(32'd4711);
    #5;
    chk("R1 reset", {sclk_o, lead_o, trail_o}, 3'b000);
    repeat (2) @(negedge clk_i);
    chk("R1 reset", {sclk_o, lead_o, trail_o}, 3'b000);
    rst_ni = 1'b1;
    xfer("R4 div2", {1'b0, 4'd0, 8'hA5}, 1'b0, 1'b0);
    xfer("R3 div2", {1'b1, 4'd9, 8'd0}, 1'b1, 1'b0);
    xfer("R3 lin", {1'b1, 4'd3, 8'd4}, 1'b0, 1'b0);
    xfer("R4 pow2", {1'b0, 4'd4, 8'd0}, 1'b1, 1'b0);
    xfer("R5 first half", {1'b0, 4'd10, 8'h3C}, 1'b0, 1'b0);
    xfer("R3 lin max", {1'b1, 4'd0, 8'd255}, 1'b0, 1'b0);
    xfer("R8", {1'b1, 4'd2, 8'd5}, 1'b0, 1'b1);
    xfer("R8 next uses new", {1'b0, 4'd2, 8'd0}, 1'b1, 1'b1);
    // cpol change while idle is taken up (R2)
    @(negedge clk_i); cpol_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R2 cpol follow", {sclk_o, lead_o, trail_o}, 3'b000);
    for (int i = 0; i < 20; i++) begin
      logic [12:0] c;
      c = 13'($urandom);
      if (!c[12]) c[11:8] = {1'b0, c[10:8]};
      xfer(c[12] ? "R3 rand" : "R4 rand", c, 1'($urandom), 1'b0);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule